// File: doc/BRIEF.md
# Six-Digit Multiplexed Seven-Segment Scanner

This block drives a six-digit seven-segment time readout whose digits share one set of segment lines. It takes hours, minutes and seconds as three packed BCD bytes, tens in the upper nibble. It lights one digit at a time through a one-hot digit enable and steps through the six digits in a fixed order.

Each digit is held for a parameterised number of clock cycles. The last few cycles of every hold are spent with all segments dark, so the pattern of one digit never shows on the next. The active levels of the segment and digit lines are set by parameters, which lets the same block drive common-cathode or common-anode parts. Two further parameters add optional features. One suppresses a leading zero in the hours. The other makes the decimal points used as separators blink from an external once-per-second tick.

Top module: `seg_scan`

## Requirements
- R1: While reset is held, and until the first hold period ends after release, the enable for digit 0 (hours tens) is the only one active.
- R2: Exactly one digit enable is active in every cycle.
- R3: Each digit is held for exactly DWELL_CYCLES cycles. The enable then moves to the next digit in the order hours tens, hours units, minutes tens, minutes units, seconds tens, seconds units, and wraps back to hours tens. Digit i is dig_o bit i.
- R4: During the last BLANK_CYCLES cycles of every hold, all eight segment outputs, decimal point included, are inactive. During the cycles before that, the digit's pattern is shown.
- R5: A BCD value from 0 to 9 lights the standard pattern on seg_o = {dp,g,f,e,d,c,b,a}, with bit 0 = a. The patterns in active-high form are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. A "1" lights only b and c, and an "8" lights a through g.
- R6: A nibble from 10 to 15 shows a blank digit, with all segments a through g inactive.
- R7: SEG_ACTIVE_HIGH=0 inverts every segment line, and DIG_ACTIVE_HIGH=0 inverts every digit line. Timing is unchanged.
- R8: When HIDE_LEAD_ZERO=1 and the hours tens nibble is 0, the hours tens digit stays blank. A nonzero hours tens value is shown normally.
- R9: The decimal point is active only on the hours units and minutes units digits, outside the blanking window. It is never active on the other digits.
- R10: When BLINK_SEP=1, each one-cycle pulse on sep_tick_i toggles whether the separators are shown, and they are shown after reset. When BLINK_SEP=0, the tick has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hours_i | input | 8 | Hours as packed BCD, tens in [7:4] |
| mins_i | input | 8 | Minutes as packed BCD, tens in [7:4] |
| secs_i | input | 8 | Seconds as packed BCD, tens in [7:4] |
| sep_tick_i | input | 1 | One-cycle pulse that toggles the separator blink phase |
| seg_o | output | 8 | Segment lines {dp,g,f,e,d,c,b,a} at the chosen polarity |
| dig_o | output | 6 | Digit enables, bit 0 = hours tens, at the chosen polarity |

## Verification
The hardest situation to reach from the ports is a given digit inside a given cycle of its hold, because the scan runs freely and never waits for the inputs. The bench locks onto the cycle where the wanted digit's enable first rises. It sets the BCD inputs beforehand and takes every sample at a fixed offset from that edge, so lit cycles and blanked cycles are told apart. A second instance built with the opposite polarities and with both options off receives the same stimulus. This lets inversion, zero suppression and an ignored tick be compared in the same cycles.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int NUM_DIGITS = 6;
  localparam int IDX_W      = 3;

  // segment vector {g,f,e,d,c,b,a}, active high
  typedef logic [6:0] seg7_t;

  function automatic seg7_t bcd_to_seg(input logic [3:0] v);
    seg7_t s;
    case (v)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;   // non-BCD codes stay dark
    endcase
    return s;
  endfunction
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int DWELL_CYCLES = 50000,
  parameter int BLANK_CYCLES = 500
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  output logic [scan_pkg::IDX_W-1:0] idx_o,
  output logic                     blank_o
);
  import scan_pkg::*;

  localparam int CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST  = CW'(DWELL_CYCLES - 1);
  localparam logic [CW-1:0] BLANK_AT  = CW'(DWELL_CYCLES - BLANK_CYCLES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIGITS - 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             hold_end;

  assign hold_end = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    idx_d = idx_q;
    if (hold_end) begin
      cnt_d = '0;
      idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign idx_o   = idx_q;
  assign blank_o = (cnt_q >= BLANK_AT);
endmodule

// File: rtl/seg_decode.sv
module seg_decode (
  input  logic [3:0]            bcd_i,
  input  logic                  show_i,
  output scan_pkg::seg7_t       seg_o
);
  import scan_pkg::*;

  always_comb begin
    seg_o = show_i ? bcd_to_seg(bcd_i) : '0;
  end
endmodule

// File: rtl/seg_scan.sv
module seg_scan #(
  parameter int DWELL_CYCLES    = 50000,
  parameter int BLANK_CYCLES    = 500,
  parameter bit SEG_ACTIVE_HIGH = 1'b1,
  parameter bit DIG_ACTIVE_HIGH = 1'b1,
  parameter bit HIDE_LEAD_ZERO  = 1'b1,
  parameter bit BLINK_SEP       = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] hours_i,
  input  logic [7:0] mins_i,
  input  logic [7:0] secs_i,
  input  logic       sep_tick_i,
  output logic [7:0] seg_o,
  output logic [5:0] dig_o
);
  import scan_pkg::*;

  logic             rst_sync_n;
  logic [IDX_W-1:0] idx;
  logic             blank;
  logic [3:0]       nib;
  logic             show;
  seg7_t            seg_lit;
  logic             dp_lit;
  logic             phase_q, phase_d;
  logic [NUM_DIGITS-1:0] dig_act;

  scan_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  scan_timer #(
    .DWELL_CYCLES (DWELL_CYCLES),
    .BLANK_CYCLES (BLANK_CYCLES)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .idx_o   (idx),
    .blank_o (blank)
  );

  // digit order: h tens, h units, m tens, m units, s tens, s units
  always_comb begin
    case (idx)
      3'd0:    nib = hours_i[7:4];
      3'd1:    nib = hours_i[3:0];
      3'd2:    nib = mins_i[7:4];
      3'd3:    nib = mins_i[3:0];
      3'd4:    nib = secs_i[7:4];
      default: nib = secs_i[3:0];
    endcase
  end

  always_comb begin
    show = !blank;
    if (HIDE_LEAD_ZERO && idx == 3'd0 && nib == 4'd0) show = 1'b0;
  end

  seg_decode u_dec (
    .bcd_i  (nib),
    .show_i (show),
    .seg_o  (seg_lit)
  );

  // separator blink phase, clock enable written out
  always_comb begin
    phase_d = phase_q;
    if (BLINK_SEP && sep_tick_i) phase_d = ~phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) phase_q <= 1'b1;
    else             phase_q <= phase_d;
  end

  assign dp_lit = !blank && (idx == 3'd1 || idx == 3'd3) && (!BLINK_SEP || phase_q);

  generate
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
      assign dig_act[i] = (idx == IDX_W'(i));
    end
    if (SEG_ACTIVE_HIGH) begin : g_seg_hi
      assign seg_o = {dp_lit, seg_lit};
    end else begin : g_seg_lo
      assign seg_o = ~{dp_lit, seg_lit};
    end
    if (DIG_ACTIVE_HIGH) begin : g_dig_hi
      assign dig_o = dig_act;
    end else begin : g_dig_lo
      assign dig_o = ~dig_act;
    end
  endgenerate
endmodule

// File: rtl/seg_scan_checker.sv
module seg_scan_checker #(
  parameter int DWELL_CYCLES    = 50000,
  parameter int BLANK_CYCLES    = 500,
  parameter bit SEG_ACTIVE_HIGH = 1'b1,
  parameter bit DIG_ACTIVE_HIGH = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] seg_o,
  input logic [5:0] dig_o
);
  localparam int CW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST     = CW'(DWELL_CYCLES - 1);
  localparam logic [CW-1:0] BLANK_AT = CW'(DWELL_CYCLES - BLANK_CYCLES);

  logic [CW-1:0] cyc_q;
  logic [7:0]    seg_a;
  logic [5:0]    dig_a;

  assign seg_a = SEG_ACTIVE_HIGH ? seg_o : ~seg_o;
  assign dig_a = DIG_ACTIVE_HIGH ? dig_o : ~dig_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q == LAST) cyc_q <= '0;
    else                    cyc_q <= cyc_q + CW'(1);
  end

  assert_one_digit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dig_a) == 1);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != LAST) |=> $stable(dig_a));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == LAST) |=> (dig_a == {$past(dig_a[4:0]), $past(dig_a[5])}));

  assert_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= BLANK_AT) |-> (seg_a == 8'h00));

  assert_dp_place_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_a[7] |-> (dig_a[1] || dig_a[3]));
endmodule

bind seg_scan seg_scan_checker #(
  .DWELL_CYCLES    (DWELL_CYCLES),
  .BLANK_CYCLES    (BLANK_CYCLES),
  .SEG_ACTIVE_HIGH (SEG_ACTIVE_HIGH),
  .DIG_ACTIVE_HIGH (DIG_ACTIVE_HIGH)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_sync_n),
  .seg_o  (seg_o),
  .dig_o  (dig_o)
);

// File: tb/seg_scan_test.sv
module seg_scan_test;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL      = 8;
  localparam int BLANK      = 2;

  logic       clk, rst_n, tick;
  logic [7:0] hours, mins, secs;
  logic [7:0] seg_a, seg_b;
  logic [5:0] dig_a, dig_b;
  int checks = 0;
  int fails  = 0;

  // instance with high polarity, zero hiding and blinking on
  seg_scan #(.DWELL_CYCLES(DWELL), .BLANK_CYCLES(BLANK), .SEG_ACTIVE_HIGH(1'b1),
             .DIG_ACTIVE_HIGH(1'b1), .HIDE_LEAD_ZERO(1'b1), .BLINK_SEP(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hours_i(hours), .mins_i(mins), .secs_i(secs),
    .sep_tick_i(tick), .seg_o(seg_a), .dig_o(dig_a));

  // inverted polarity, options off
  seg_scan #(.DWELL_CYCLES(DWELL), .BLANK_CYCLES(BLANK), .SEG_ACTIVE_HIGH(1'b0),
             .DIG_ACTIVE_HIGH(1'b0), .HIDE_LEAD_ZERO(1'b0), .BLINK_SEP(1'b0)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .hours_i(hours), .mins_i(mins), .secs_i(secs),
    .sep_tick_i(tick), .seg_o(seg_b), .dig_o(dig_b));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] pattern(input int v);
    case (v)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // wait for the first cycle of digit k's hold on uut
  task automatic wait_start(input int k);
    logic [5:0] prev;
    prev = dig_a;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (dig_a == 6'(1 << k) && prev != dig_a) return;
      prev = dig_a;
    end
    check(1'b0, "R3", "digit start not found", 32'(dig_a), 32'(1 << k));
  endtask

  task automatic grab(input int k, output logic [7:0] sa, output logic [7:0] sb);
    wait_start(k);
    sa = seg_a;
    sb = seg_b;
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(dig_a == 6'b000001, "R1", "dig in reset", 32'(dig_a), 32'h01);
    check(dig_b == 6'b111110, "R1", "inverted dig in reset", 32'(dig_b), 32'h3E);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dig_a == 6'b000001, "R1", "dig after release", 32'(dig_a), 32'h01);
  endtask

  task automatic test_order_dwell;
    int bad_a = 0, bad_b = 0;
    wait_start(0);
    for (int n = 0; n < 6 * DWELL + 1; n++) begin
      logic [5:0] exp;
      exp = 6'(1 << ((n / DWELL) % 6));
      if (dig_a != exp) bad_a++;
      if (dig_b != ~exp) bad_b++;
      if (n < 6 * DWELL) @(negedge clk);
    end
    // R3 order and hold length, R2 single enable
    check(bad_a == 0, "R3", "scan order/dwell mismatches", 32'(bad_a), 0);
    check(bad_b == 0, "R2", "inverted one-hot mismatches", 32'(bad_b), 0);
  endtask

  task automatic test_decode;
    logic [7:0] sa, sb;
    int bad = 0;
    hours = 8'h23; mins = 8'h45;
    for (int v = 0; v < 10; v++) begin
      secs = 8'(v);
      grab(5, sa, sb);
      if (sa != {1'b0, pattern(v)}) begin
        bad++;
        check(1'b0, "R5", "digit pattern", 32'(sa), 32'({1'b0, pattern(v)}));
      end
      if (sb != ~{1'b0, pattern(v)}) begin
        bad++;
        check(1'b0, "R7", "inverted pattern", 32'(sb), 32'(~{1'b0, pattern(v)}));
      end
    end
    check(bad == 0, "R5", "decode sweep errors", 32'(bad), 0);
    secs = 8'h08;
    grab(5, sa, sb);
    check(sa == 8'h7F, "R5", "eight lights a-g", 32'(sa), 32'h7F);
    secs = 8'h01;
    grab(5, sa, sb);
    check(sa == 8'h06, "R5", "one lights b,c", 32'(sa), 32'h06);
  endtask

  task automatic test_invalid;
    logic [7:0] sa, sb;
    for (int v = 10; v < 16; v++) begin
      secs = 8'(v << 4) | 8'(v);
      grab(4, sa, sb);
      check(sa == 8'h00, "R6", "non-BCD tens blank", 32'(sa), 0);
      @(negedge clk);
      wait_start(5);
      check(seg_b == 8'hFF, "R6", "non-BCD units blank inverted", 32'(seg_b), 32'hFF);
    end
    secs = 8'h00;
  endtask

  task automatic test_blank;
    int bad = 0;
    hours = 8'h18;
    wait_start(1);
    for (int n = 0; n < DWELL; n++) begin
      logic [7:0] ea;
      ea = (n < DWELL - BLANK) ? 8'hFF : 8'h00;
      if (seg_a != ea || seg_b != ~ea) begin
        bad++;
        check(1'b0, "R4", "segment level in hold", 32'(seg_a), 32'(ea));
      end
      if (n < DWELL - 1) @(negedge clk);
    end
    check(bad == 0, "R4", "blanking window errors", 32'(bad), 0);
  endtask

  task automatic test_lead_zero;
    logic [7:0] sa, sb;
    hours = 8'h05;
    grab(0, sa, sb);
    // R8
    check(sa == 8'h00, "R8", "hidden leading zero", 32'(sa), 0);
    check(sb == ~{1'b0, 7'h3F}, "R8", "zero shown when option off", 32'(sb), 32'hC0);
    hours = 8'h15;
    grab(0, sa, sb);
    check(sa == 8'h06, "R8", "nonzero tens shown", 32'(sa), 32'h06);
  endtask

  task automatic test_dp;
    logic [7:0] sa, sb;
    hours = 8'h12; mins = 8'h34;
    grab(1, sa, sb);
    check(sb[7] == 1'b0, "R9", "dp on hours units", 32'(sb[7]), 0);
    grab(2, sa, sb);
    check(sa[7] == 1'b0 && sb[7] == 1'b1, "R9", "dp off minutes tens", 32'(sa[7]), 0);
    grab(3, sa, sb);
    check(sa[7] == 1'b1, "R9", "dp on minutes units", 32'(sa[7]), 1);
    grab(0, sa, sb);
    check(sa[7] == 1'b0, "R9", "dp off hours tens", 32'(sa[7]), 0);
  endtask

  task automatic test_blink;
    logic [7:0] sa, sb;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    grab(1, sa, sb);
    // R10
    check(sa[7] == 1'b0, "R10", "separator hidden after tick", 32'(sa[7]), 0);
    check(sb[7] == 1'b0, "R10", "tick ignored when blink off", 32'(sb[7]), 0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    grab(3, sa, sb);
    check(sa[7] == 1'b1, "R10", "separator back after second tick", 32'(sa[7]), 1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0;
    hours = 8'h12; mins = 8'h34; secs = 8'h56;
    @(negedge clk);
    test_reset();
    test_order_dwell();
    test_decode();
    test_invalid();
    test_blank();
    test_lead_zero();
    test_dp();
    test_blink();
    finish_run();
  end
endmodule